// File: doc/BRIEF.md
# Interrupt Flag and Vector Arbiter

This block gathers event pulses from a set of interrupt sources and records each in its own pending flag. A per-source enable mask and a single global enable decide which flags may turn into a request. At an instruction-boundary strobe from the core, the arbiter picks the lowest-numbered source that is both pending and enabled. It raises a request with that source's vector index and holds both until the core acknowledges.

The acknowledge is the moment the interrupt is taken. In that cycle the hardware clears the chosen source's flag and drops the global enable. A return strobe or a set-enable strobe turns the global enable back on. After either strobe, one more instruction boundary must pass before a new request can be raised, so at least one main-line instruction runs between back-to-back interrupts. An event that arrives in the acknowledge cycle, or at any time while the handler runs, sets the flag again, so that event is serviced after the return.

A source may instead be put in level mode. Its request then follows its input directly and it never keeps a flag. Software clears flags by writing ones through the register port, and writes the enable mask through the same port.

Top module: `irq_vector_arbiter`

## Requirements
- R1: After reset, no request is raised, the global enable is 0, all flags are clear and all enables are 0. So enabling every source and setting the global enable produces no request unless new events arrive.
- R2: An event pulse on an edge-mode source sets its flag even while that source's enable or the global enable is 0. The flag stays set until the interrupt is taken or software clears it.
- R3: An acknowledge clears the flag of the source whose index is on `vec_o`. The same event is therefore not requested a second time.
- R4: An event for a source arriving in the same cycle as that source's acknowledge, or while its handler runs, leaves the flag set. Another request for it follows the return.
- R5: When several enabled sources are pending at the same boundary, the lowest index is reported on `vec_o`. The others stay pending and are taken later in index order.
- R6: `irq_o` rises only in the cycle after a `boundary_i` strobe. While `irq_o` is 1 and no acknowledge has come, `irq_o` stays 1 and `vec_o` does not change, even if new events arrive.
- R7: An acknowledge while `irq_o` is 1 drops `irq_o` and clears `gie_o` on the next edge. A `reti_i` or `sei_i` strobe sets `gie_o`.
- R8: After a `sei_i` or `reti_i` strobe, the first following boundary raises no request. The boundary after that one may raise a request.
- R9: A register write with `wr_sel_i` = 1 clears every flag whose bit in `wr_data_i` is 1 and leaves the flags with a 0 bit alone. A write with `wr_sel_i` = 0 loads `wr_data_i` into the enable mask, bit k enabling source k.
- R10: A source with its `lvl_mode_i` bit at 1 requests only while its `evt_i` bit is 1 and never latches a flag. A pulse that has gone away before the boundary raises no request.
- R11: A source whose enable bit is 0 is never requested, whatever its flag.
- R12: If the global enable is set again inside a handler, any enabled pending source can be requested, including one with a higher index than the source being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | N | Per-source event pulse in edge mode, request level in level mode |
| lvl_mode_i | input | N | Per-source level-mode select |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0: write the enable mask, 1: write-one-to-clear the flags |
| wr_data_i | input | N | Register write data, one bit per source |
| boundary_i | input | 1 | Instruction-boundary strobe from the core |
| sei_i | input | 1 | Set-global-enable strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ack_i | input | 1 | Vector acknowledge from the core |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | IW | Index of the requested source |
| gie_o | output | 1 | Global interrupt enable |

## Verification
Every result of this block appears one rising edge after the strobe that causes it. A boundary strobe shows up on `irq_o`/`vec_o` after one edge. An acknowledge shows up on `irq_o`, `gie_o` and the flag after one edge. A flag write or an event takes effect on the flag after one edge, and so it can affect a request only at a later boundary. The bench drives each strobe for exactly one cycle on the falling edge and samples on the following falling edge, so each check reads the value due after the single register stage. The sweep covers every pending pattern against every enable mask for a four-source configuration. It walks the boundaries blocked by the gap, the first request, and the follow-on request after return, and computes the expected index as the lowest set bit of the masked pattern.

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  evt_i,
  input  logic [N-1:0]  lvl_mode_i,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [N-1:0]  wr_data_i,
  input  logic          boundary_i,
  input  logic          sei_i,
  input  logic          reti_i,
  input  logic          ack_i,
  output logic          irq_o,
  output logic [IW-1:0] vec_o,
  output logic          gie_o
);

  logic [N-1:0]  en_q, flag_q, flag_d, src_req, take_clr, sw_clr;
  logic          gie_q, hold_q, irq_q, any;
  logic [IW-1:0] vec_q, win;

  assign src_req = en_q & ((lvl_mode_i & evt_i) | (~lvl_mode_i & flag_q));

  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (src_req[i]) begin
        win = IW'(i);
        any = 1'b1;
      end
    end
  end

  wire take   = irq_q & ack_i;
  wire strobe = sei_i | reti_i;
  wire raise  = boundary_i & gie_q & ~hold_q & ~strobe & ~irq_q & any;

  always_comb begin
    for (int i = 0; i < N; i++) take_clr[i] = take && (vec_q == IW'(i));
  end

  assign sw_clr = (wr_en_i && wr_sel_i) ? wr_data_i : '0;
  assign flag_d = ((flag_q & ~take_clr & ~sw_clr) | evt_i) & ~lvl_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      flag_q <= '0;
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
      irq_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (wr_en_i && !wr_sel_i) en_q <= wr_data_i;
      if (take)        gie_q <= 1'b0;
      else if (strobe) gie_q <= 1'b1;
      if (strobe)          hold_q <= 1'b1;
      else if (boundary_i) hold_q <= 1'b0;
      if (raise) begin
        irq_q <= 1'b1;
        vec_q <= win;
      end else if (take) begin
        irq_q <= 1'b0;
      end
    end
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;
  assign gie_o = gie_q;

  // R6
  hold_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !ack_i |=> irq_o && $stable(vec_o));

  // R6
  rise_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(boundary_i));

  // R7
  take_drops_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && ack_i && !sei_i && !reti_i |=> !gie_o && !irq_o);

  // R8
  gap_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sei_i || reti_i |=> !$rose(irq_o));

  // R10
  level_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_mode_i != '0 |=> (flag_q & $past(lvl_mode_i)) == '0);

  // R4
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i & ~lvl_mode_i) != '0 |=>
      (flag_q & $past(evt_i & ~lvl_mode_i)) == $past(evt_i & ~lvl_mode_i));

endmodule

// File: tb/irq_vector_arbiter_tb.sv
module irq_vector_arbiter_tb_top;
  localparam int N  = 4;
  localparam int IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] evt = '0, lvl = '0, wdat = '0;
  logic wen = 1'b0, wsel = 1'b0, bnd = 1'b0, sei = 1'b0, reti = 1'b0, ack = 1'b0;
  logic irq, gie;
  logic [IW-1:0] vec;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_vector_arbiter #(.N(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .lvl_mode_i(lvl),
    .wr_en_i(wen), .wr_sel_i(wsel), .wr_data_i(wdat),
    .boundary_i(bnd), .sei_i(sei), .reti_i(reti), .ack_i(ack),
    .irq_o(irq), .vec_o(vec), .gie_o(gie));

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: act=%0d exp=%0d", cycles, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask
  task automatic pulse_evt(input logic [N-1:0] m); evt = m; cyc(); evt = '0; endtask
  task automatic boundary(); bnd = 1'b1; cyc(); bnd = 1'b0; endtask
  task automatic do_sei(); sei = 1'b1; cyc(); sei = 1'b0; endtask
  task automatic do_reti(); reti = 1'b1; cyc(); reti = 1'b0; endtask
  task automatic do_ack(); ack = 1'b1; cyc(); ack = 1'b0; endtask
  task automatic wr(input logic s, input logic [N-1:0] d);
    wen = 1'b1; wsel = s; wdat = d; cyc(); wen = 1'b0; wdat = '0;
  endtask

  function automatic int lowest(input int m);
    for (int i = N - 1; i >= 0; i--) if (m[i]) lowest = i;
    if (m == 0) lowest = -1;
  endfunction

  task automatic expect_req(input int idx, input string r);
    if (idx < 0) chk(irq == 1'b0, r, irq, 0);
    else begin
      chk(irq == 1'b1, r, irq, 1);
      chk(vec == IW'(idx), r, vec, idx);
    end
  endtask

  task automatic cleanup();
    if (irq) do_ack();
    lvl = '0;
    wr(1'b1, '1);
    wr(1'b0, '0);
  endtask

  initial begin
    repeat (2) cyc();
    rst_n = 1'b1;
    cyc();
    // R1
    chk(irq == 1'b0, "R1", irq, 0);
    chk(gie == 1'b0, "R1", gie, 0);
    wr(1'b0, '1);
    do_sei();
    chk(gie == 1'b1, "R7", gie, 1);
    boundary();
    boundary();
    expect_req(-1, "R1");
    cleanup();

    // sweep: R2 R3 R5 R8 R11
    for (int en = 0; en < 16; en++) begin
      for (int pat = 1; pat < 16; pat++) begin
        int m, w;
        m = pat & en;
        w = lowest(m);
        wr(1'b0, N'(en));
        pulse_evt(N'(pat));
        do_sei();
        boundary();
        expect_req(-1, "R8");
        boundary();
        expect_req(w, "R5_R11_R2");
        if (w >= 0) begin
          do_ack();
          chk(gie == 1'b0 && irq == 1'b0, "R7", gie, 0);
          do_reti();
          boundary();
          expect_req(-1, "R8");
          boundary();
          expect_req(lowest(m & ~(1 << w)), "R3_R5");
        end
        cleanup();
      end
    end

    // R4: event in ack cycle is kept
    wr(1'b0, 4'b0001);
    pulse_evt(4'b0001);
    do_sei(); boundary(); boundary();
    expect_req(0, "R4");
    ack = 1'b1; evt = 4'b0001; cyc(); ack = 1'b0; evt = '0;
    chk(gie == 1'b0, "R7", gie, 0);
    do_reti(); boundary(); boundary();
    expect_req(0, "R4");
    do_ack();
    pulse_evt(4'b0001);
    do_reti(); boundary(); boundary();
    expect_req(0, "R4");
    do_ack();
    do_reti(); boundary(); boundary();
    expect_req(-1, "R3");
    cleanup();

    // R6: request only at boundary, held stable
    wr(1'b0, 4'b1111);
    pulse_evt(4'b0100);
    do_sei(); boundary();
    repeat (3) cyc();
    expect_req(-1, "R6");
    boundary();
    expect_req(2, "R6");
    pulse_evt(4'b0001);
    boundary();
    repeat (2) cyc();
    expect_req(2, "R6");
    cleanup();

    // R9: write-one-to-clear
    wr(1'b0, 4'b1111);
    pulse_evt(4'b0110);
    wr(1'b1, 4'b1010);
    do_sei(); boundary(); boundary();
    expect_req(2, "R9");
    do_ack();
    wsel = 1'b1; wen = 1'b1; wdat = 4'b0100; evt = 4'b0100; cyc();
    wen = 1'b0; wdat = '0; evt = '0;
    do_reti(); boundary(); boundary();
    expect_req(2, "R9");
    cleanup();

    // R10: level mode
    lvl = 4'b1000;
    wr(1'b0, 4'b1000);
    pulse_evt(4'b1000);
    do_sei(); boundary(); boundary();
    expect_req(-1, "R10");
    evt = 4'b1000;
    boundary();
    expect_req(3, "R10");
    do_ack();
    evt = '0;
    do_reti(); boundary(); boundary();
    expect_req(-1, "R10");
    cleanup();

    // R12: nesting allows a higher index
    wr(1'b0, 4'b1111);
    pulse_evt(4'b0001);
    do_sei(); boundary(); boundary();
    expect_req(0, "R12");
    do_ack();
    pulse_evt(4'b1000);
    boundary(); boundary();
    expect_req(-1, "R7");
    do_sei(); boundary(); boundary();
    expect_req(3, "R12");
    cleanup();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule